// File: doc/BRIEF.md
# Masked Port Mismatch Detector

This block watches two general-purpose input ports of eight pins each and reports when any of their pins leaves a programmed resting pattern. Each port has two software-written registers. One holds the expected level of every pin. The other is a per-pin select that decides whether the pin takes part in the comparison. The pins are compared after a synchroniser. The comparison uses the raw pin levels, so it does not depend on how the pins are routed elsewhere in the chip.

The mismatch results of the two ports are ORed into a single event. A global enable gates that event into two outputs. The first is a sticky interrupt flag, which software clears by writing 1 to a clear bit. The second is a combinational wake request for a power controller. The live comparison result can always be read back, even while the enable is off.

The register interface is a single-cycle write strobe with a small address. Reads are combinational from the same address.

Top module: `pmm_top`

## Requirements
- R1: Each port has a match register: port 0 at address 0 and port 1 at address 1. Both reset to 0xFF and read back the last value written to them.
- R2: Each port has a mask register: port 0 at address 2 and port 1 at address 3. Both reset to 0x00 and read back the last value written to them.
- R3: A port mismatches when (synchronised pins AND mask) differs from (match AND mask). A pin whose mask bit is 0 has no effect on the result.
- R4: The mismatch event is the OR of the two port results. A mismatch on either port alone raises it.
- R5: A pin change reaches the comparison after exactly two rising clock edges, through a two-flop synchroniser.
- R6: `wake` is high exactly while the enable bit is 1 and the mismatch event is present. It follows the comparison without waiting for the flag.
- R7: The flag is set at a rising edge where the enable is 1 and the mismatch event is present. It then stays set, and `irq` shows it.
- R8: Writing the control register (address 4) with bit 1 set clears the flag on that edge. If the mismatch is still present, the flag sets again on the following edge.
- R9: The enable is control bit 0 and resets to 0. While it is 0, the flag is never set and `wake` stays low, but the status bit still shows the mismatch.
- R10: Reading the control register returns bit 0 = enable, bit 1 = flag and bit 2 = live mismatch, with all other bits 0. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 16 | Port pins; port 0 on bits 7:0, port 1 on bits 15:8 |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Sticky mismatch interrupt flag |
| wake_o | output | 1 | Wake request: enable AND live mismatch |

## Verification
The bench checks that toggling a pin whose mask bit is 0 never moves the status bit. A design that forgot the mask would report false events. It measures the pin-to-status latency edge by edge: a missing or extra synchroniser stage would show the change one cycle early or late. It writes a clear while the mismatch is still present. A design that let the set win over the clear, or that never re-armed the flag, would hold the flag high or leave it low on the following edge. It also confirms that a disabled block keeps `wake` and `irq` low while the status bit still reads 1, and that a mismatch on port 1 alone raises the event.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
   // Control/status register bit positions
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_FLAG_BIT = 1;
   localparam int CTL_STAT_BIT = 2;
   localparam int CTL_MIN_W    = 3;
endpackage

// File: rtl/pmm_sync.sv
module pmm_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= '0;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pmm_cmp.sv
module pmm_cmp #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   localparam int TOT_W    = PORT_W * NUM_PORTS
) (
   input  logic [TOT_W-1:0]     pins_i,
   input  logic [TOT_W-1:0]     match_i,
   input  logic [TOT_W-1:0]     mask_i,
   output logic [NUM_PORTS-1:0] port_mis_o,
   output logic                 any_mis_o
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] diff;
      assign diff          = (pins_i[p*PORT_W +: PORT_W] ^ match_i[p*PORT_W +: PORT_W])
                             & mask_i[p*PORT_W +: PORT_W];
      assign port_mis_o[p] = |diff;
   end

   assign any_mis_o = |port_mis_o;
endmodule

// File: rtl/pmm_regs.sv
module pmm_regs
   import pmm_pkg::*;
#(
   parameter int               PORT_W    = 8,
   parameter int               NUM_PORTS = 2,
   parameter int               ADDR_W    = 3,
   parameter logic [PORT_W-1:0] MATCH_RST = '1,
   parameter logic [PORT_W-1:0] MASK_RST  = '0,
   localparam int              TOT_W     = PORT_W * NUM_PORTS,
   localparam int              CTRL_ADDR = 2 * NUM_PORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PORT_W-1:0] wdata_i,
   input  logic              mis_i,
   output logic [TOT_W-1:0]  match_o,
   output logic [TOT_W-1:0]  mask_o,
   output logic              en_o,
   output logic              flag_o,
   output logic [PORT_W-1:0] rdata_o
);
   logic ctrl_wr;
   logic clr;
   logic en_q;
   logic flag_q;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] match_q;
      logic [PORT_W-1:0] mask_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    match_q <= MATCH_RST;
         else if (wr_en_i && addr_i == ADDR_W'(p))      match_q <= wdata_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                          mask_q <= MASK_RST;
         else if (wr_en_i && addr_i == ADDR_W'(NUM_PORTS + p)) mask_q <= wdata_i;
      end

      assign match_o[p*PORT_W +: PORT_W] = match_q;
      assign mask_o[p*PORT_W +: PORT_W]  = mask_q;
   end

   assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR));
   assign clr     = ctrl_wr && wdata_i[CTL_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (ctrl_wr) en_q <= wdata_i[CTL_EN_BIT];
   end

   // Clear wins over set; a persisting mismatch re-sets the flag one edge later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag_q <= 1'b0;
      else if (clr)            flag_q <= 1'b0;
      else if (en_q && mis_i)  flag_q <= 1'b1;
   end

   always_comb begin
      rdata_o = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr_i == ADDR_W'(p))             rdata_o = match_o[p*PORT_W +: PORT_W];
         if (addr_i == ADDR_W'(NUM_PORTS + p)) rdata_o = mask_o[p*PORT_W +: PORT_W];
      end
      if (addr_i == ADDR_W'(CTRL_ADDR)) begin
         rdata_o[CTL_EN_BIT]   = en_q;
         rdata_o[CTL_FLAG_BIT] = flag_q;
         rdata_o[CTL_STAT_BIT] = mis_i;
      end
   end

   assign en_o   = en_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/pmm_top.sv
module pmm_top
   import pmm_pkg::*;
#(
   parameter int               PORT_W      = 8,
   parameter int               NUM_PORTS   = 2,
   parameter int               ADDR_W      = 3,
   parameter int               SYNC_STAGES = 2,
   parameter logic [PORT_W-1:0] MATCH_RST   = '1,
   parameter logic [PORT_W-1:0] MASK_RST    = '0,
   localparam int              TOT_W       = PORT_W * NUM_PORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TOT_W-1:0]  pins_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PORT_W-1:0] wdata_i,
   output logic [PORT_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              wake_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pmm_top: SYNC_STAGES must be at least 2");
   end
   if (PORT_W < CTL_MIN_W) begin : g_bad_width
      $error("pmm_top: PORT_W too small for the control register");
   end
   if (2 * NUM_PORTS + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("pmm_top: ADDR_W cannot cover the register map");
   end

   logic [TOT_W-1:0]     pins_s;
   logic [TOT_W-1:0]     match;
   logic [TOT_W-1:0]     mask;
   logic [NUM_PORTS-1:0] port_mis;
   logic                 any_mis;
   logic                 en;
   logic                 flag;

   pmm_sync #(.W(TOT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_i),
      .q_o   (pins_s)
   );

   pmm_cmp #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_cmp (
      .pins_i     (pins_s),
      .match_i    (match),
      .mask_i     (mask),
      .port_mis_o (port_mis),
      .any_mis_o  (any_mis)
   );

   pmm_regs #(
      .PORT_W    (PORT_W),
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .MATCH_RST (MATCH_RST),
      .MASK_RST  (MASK_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .mis_i   (any_mis),
      .match_o (match),
      .mask_o  (mask),
      .en_o    (en),
      .flag_o  (flag),
      .rdata_o (rdata_o)
   );

   assign irq_o  = flag;
   assign wake_o = en & any_mis;
endmodule

// File: rtl/pmm_chk.sv
module pmm_chk #(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [PORT_W-1:0] wdata_i,
   input logic              irq_o,
   input logic              wake_o,
   input logic              en,
   input logic              any_mis
);
   logic clr_w;
   assign clr_w = wr_en_i && (addr_i == ADDR_W'(2 * NUM_PORTS)) && wdata_i[1];

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_w) |=> irq_o);

   // R7
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && any_mis && !clr_w) |=> irq_o);

   // R8
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> !irq_o);

   // R9
   disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !irq_o) |=> !irq_o);

   // R9
   disabled_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !wake_o);

   // R6
   wake_feeds_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_o && !clr_w) |=> irq_o);
endmodule

bind pmm_top pmm_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .irq_o   (irq_o),
   .wake_o  (wake_o),
   .en      (en),
   .any_mis (any_mis)
);

// File: tb/tb_pmm_top.sv
module tb_pmm_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pins = 16'h0000;
   logic        wr = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata;
   logic        irq;
   logic        wake;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pmm_top dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
   );

   // Behavioural reference model
   logic [7:0]  m_match [2];
   logic [7:0]  m_mask  [2];
   logic        m_en;
   logic        m_flag;
   logic [15:0] m_hist [$];

   function automatic logic m_mis();
      logic r = 1'b0;
      logic [15:0] seen = (m_hist.size() >= 2) ? m_hist[0] : 16'h0000;
      for (int p = 0; p < 2; p++)
         if (((seen[p*8 +: 8] & m_mask[p]) != (m_match[p] & m_mask[p]))) r = 1'b1;
      return r;
   endfunction

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_match[0];
         3'd1: return m_match[1];
         3'd2: return m_mask[0];
         3'd3: return m_mask[1];
         3'd4: return {5'b0, m_mis(), m_flag, m_en};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_match[0] = 8'hFF; m_match[1] = 8'hFF;
         m_mask[0]  = 8'h00; m_mask[1]  = 8'h00;
         m_en = 1'b0; m_flag = 1'b0;
         m_hist = {16'h0000, 16'h0000};
      end else begin
         if (wr && addr == 3'd4 && wdata[1]) m_flag = 1'b0;
         else if (m_en && m_mis())           m_flag = 1'b1;
         if (wr) begin
            case (addr)
               3'd0: m_match[0] = wdata;
               3'd1: m_match[1] = wdata;
               3'd2: m_mask[0]  = wdata;
               3'd3: m_mask[1]  = wdata;
               3'd4: m_en       = wdata[0];
               default: ;
            endcase
         end
         void'(m_hist.pop_front());
         m_hist.push_back(pins);
      end
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic string rd_tag(input logic [2:0] a);
      if (a < 3'd2) return "R1";
      if (a < 3'd4) return "R2";
      return "R10";
   endfunction

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 irq",  {7'b0, irq},  {7'b0, m_flag});
         check("R6 wake", {7'b0, wake}, {7'b0, m_en & m_mis()});
         check(rd_tag(addr), rdata, m_read(addr));
      end
   end

   task automatic tick(); @(negedge clk); #1; endtask
   task automatic write(input logic [2:0] a, input logic [7:0] d);
      wr = 1'b1; addr = a; wdata = d; tick(); wr = 1'b0;
   endtask

   initial begin : watchdog
      #(8 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick(); tick();
      // reset state
      addr = 3'd0; #1; check("R1 reset match0", rdata, 8'hFF);
      addr = 3'd3; #1; check("R2 reset mask1", rdata, 8'h00);
      check("R9 reset irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;
      tick();
      addr = 3'd4; #1; check("R10 reset ctrl", rdata, 8'h00);

      // register round trip and unused address
      write(3'd0, 8'h00); write(3'd1, 8'h5A); write(3'd2, 8'h01); write(3'd3, 8'h00);
      write(3'd6, 8'hFF);
      addr = 3'd1; #1; check("R1 match1 readback", rdata, 8'h5A);
      addr = 3'd6; #1; check("R10 unused addr", rdata, 8'h00);
      write(3'd4, 8'h01);   // enable

      // R5 latency: pin 0 of port 0 goes high
      pins = 16'h0001; tick();
      check("R5 one edge", {7'b0, wake}, 8'h00);
      tick();
      check("R5 two edges", {7'b0, wake}, 8'h01);
      tick();
      check("R7 flag set", {7'b0, irq}, 8'h01);

      // R8 clear while mismatch persists
      write(3'd4, 8'h03);
      check("R8 cleared", {7'b0, irq}, 8'h00);
      tick();
      check("R8 re-set", {7'b0, irq}, 8'h01);

      // R3 masked pins ignored
      pins = 16'h00FE; repeat (3) tick();
      write(3'd4, 8'h03);
      repeat (3) tick();
      addr = 3'd4; #1;
      check("R3 masked pins", rdata, 8'h01);
      check("R3 no irq", {7'b0, irq}, 8'h00);

      // R4 port 1 alone
      write(3'd3, 8'h80);
      pins = 16'h80FE; repeat (3) tick();
      addr = 3'd4; #1;
      check("R4 port1 mismatch", {7'b0, wake}, 8'h01);

      // R9 disabled: status still visible, no wake or flag
      write(3'd4, 8'h02);
      repeat (3) tick();
      addr = 3'd4; #1;
      check("R9 status while off", rdata, 8'h04);
      check("R9 wake off", {7'b0, wake}, 8'h00);

      // mixed patterns
      for (int i = 0; i < 40; i++) begin
         pins = 16'(i * 16'h1357);
         if (i % 7 == 0) write(3'(i % 5), 8'(i * 37));
         else tick();
         addr = 3'(i % 8);
      end
      write(3'd4, 8'h01);
      for (int i = 0; i < 30; i++) begin
         pins = 16'(i * 16'h2C41);
         if (i % 9 == 0) write(3'd4, 8'h03); else tick();
         addr = 3'(i % 6);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule